// File: doc/BRIEF.md
# Radix MMU Address Qualifier

This block sits in front of a radix page-table walker. For each request it looks at the effective address, the access kind, the hypervisor-state bit and the relocation bit. It then gives one of three results. The first is a qualified logical-partition and process identifier pair, with a code naming the translation stages the walker must run. The second is a finished real-mode physical address. The third is a segment fault, with its interrupt class and the captured faulting address.

The two top bits of the effective address form a quadrant number. The quadrant picks whether the partition-identifier register and the process-identifier register are used or forced to zero. The mapping is different in hypervisor state and in guest state. The result is held in a one-deep output register that uses a valid/ready handshake on both sides.

Top module: `rmq_top`

## Requirements
- R1: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: When `in_hv`=1 and `in_reloc`=0, the result kind is 01 (real). The address is the effective address with bits 63:60 cleared, ORed with `reg_rmo` only when effective-address bit 63 is 0. Permission is 3'b111 (read, write, execute), the page shift is 12 and the stage code is 00.
- R3: Outside real mode, if any of effective-address bits 61:52 is set, the result kind is 10 (segment fault).
- R4: In hypervisor state the quadrant `in_ea[63:62]` maps to the following result identifiers (LPID, PID): 0 gives (0, register); 1 gives (register, register); 2 gives (register, 0); 3 gives (0, 0). The result kind is 00 (qualified).
- R5: In guest state, quadrant 0 gives LPID=register and PID=register. Quadrant 3 gives LPID=register and PID=0.
- R6: In guest state with relocation on or off, quadrants 1 and 2 produce a segment fault (kind 10).
- R7: On a segment fault, `out_fault_instr` is 1 when the access code is 00 (fetch) and `out_far` is 0. For access codes 01 (load), 10 (store) and 11 (treated as load), `out_fault_instr` is 0 and `out_far` holds the effective address. `out_err` is always 0. On a fault, LPID, PID and the stage code are 0.
- R8: For a qualified result, stage-code bit 0 (process-scoped) equals `in_reloc`. Bit 1 (partition-scoped) is set when the result LPID is nonzero or `in_hv` is 0. Real address, permission and page shift are 0.
- R9: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_ea | input | 64 | Effective address |
| in_acc | input | 2 | Access code: 00 fetch, 01 load, 10 store, 11 load |
| in_hv | input | 1 | Hypervisor state |
| in_reloc | input | 1 | Relocation enabled |
| reg_lpid | input | 12 | Partition-identifier register |
| reg_pid | input | 20 | Process-identifier register |
| reg_rmo | input | 64 | Real-mode offset register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed |
| out_kind | output | 2 | 00 qualified, 01 real, 10 segment fault |
| out_stages | output | 2 | Bit 0 process-scoped, bit 1 partition-scoped |
| out_lpid | output | 12 | Qualified LPID |
| out_pid | output | 20 | Qualified PID |
| out_raddr | output | 64 | Real-mode physical address |
| out_perm | output | 3 | Real-mode permission {exec, write, read} |
| out_pg_shift | output | 7 | Real-mode page-size shift |
| out_fault_instr | output | 1 | Fault is instruction-segment class |
| out_far | output | 64 | Captured fault address |
| out_err | output | 8 | Error code |

## Verification
The assertions check on every cycle that an accepted request yields a result on the next edge and that a stalled result holds still. They also check that real-mode and illegal-quadrant requests produce the right result kind, that instruction-class faults capture no address, and that a nonzero result LPID always asks for the partition stage. The exact quadrant-to-identifier mapping, the offset merge on bit 63 and the address captured for data faults can only be shown by the bench's scenarios. Those scenarios run every quadrant in both privilege states, several reserved-bit and access-type combinations, and random back-pressure, and compare the results against a behavioural model.

// File: rtl/rmq_pkg.sv
`timescale 1ns/1ps
package rmq_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    RES_QUAL = 2'd0,
    RES_REAL = 2'd1,
    RES_SEGF = 2'd2,
    RES_NONE = 2'd3
  } res_e;

  // bit 1: partition-scoped stage needed, bit 0: process-scoped stage needed
  function automatic logic [1:0] stage_code(input logic reloc, input logic hv,
                                            input logic lpid_nz);
    return {lpid_nz | ~hv, reloc};
  endfunction
endpackage

// File: rtl/rmq_quadrant.sv
`timescale 1ns/1ps
module rmq_quadrant #(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic              hv,
  input  logic [1:0]        quad,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  output logic [LPID_W-1:0] lpid_q,
  output logic [PID_W-1:0]  pid_q,
  output logic              illegal
);
  always_comb begin
    lpid_q  = '0;
    pid_q   = '0;
    illegal = 1'b0;
    if (hv) begin
      unique case (quad)
        2'd0: pid_q = pid_reg;
        2'd1: begin lpid_q = lpid_reg; pid_q = pid_reg; end
        2'd2: lpid_q = lpid_reg;
        default: ;
      endcase
    end else begin
      unique case (quad)
        2'd0: begin lpid_q = lpid_reg; pid_q = pid_reg; end
        2'd3: lpid_q = lpid_reg;
        default: illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rmq_realmode.sv
`timescale 1ns/1ps
module rmq_realmode #(
  parameter int EA_W     = 64,
  parameter int CLR_BITS = 4
) (
  input  logic [EA_W-1:0] ea,
  input  logic [EA_W-1:0] rmo,
  output logic [EA_W-1:0] raddr
);
  localparam int KEEP = EA_W - CLR_BITS;

  function automatic logic [EA_W-1:0] real_addr(input logic [EA_W-1:0] a,
                                                input logic [EA_W-1:0] off);
    logic [EA_W-1:0] base;
    base = {{CLR_BITS{1'b0}}, a[KEEP-1:0]};
    return a[EA_W-1] ? base : (base | off);
  endfunction

  assign raddr = real_addr(ea, rmo);
endmodule

// File: rtl/rmq_fault.sv
`timescale 1ns/1ps
module rmq_fault #(
  parameter int EA_W = 64
) (
  input  logic [1:0]      acc,
  input  logic [EA_W-1:0] ea,
  output logic            instr,
  output logic [EA_W-1:0] far
);
  import rmq_pkg::*;
  assign instr = (acc == ACC_FETCH);
  assign far   = instr ? '0 : ea;
endmodule

// File: rtl/rmq_top.sv
`timescale 1ns/1ps
module rmq_top #(
  parameter int EA_W         = 64,
  parameter int LPID_W       = 12,
  parameter int PID_W        = 20,
  parameter int RSV_BITS     = 10,
  parameter int CLR_BITS     = 4,
  parameter int MIN_PG_SHIFT = 12,
  parameter int ERR_W        = 8,
  localparam int PG_W        = $clog2(EA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [EA_W-1:0]   in_ea,
  input  logic [1:0]        in_acc,
  input  logic              in_hv,
  input  logic              in_reloc,
  input  logic [LPID_W-1:0] reg_lpid,
  input  logic [PID_W-1:0]  reg_pid,
  input  logic [EA_W-1:0]   reg_rmo,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [1:0]        out_stages,
  output logic [LPID_W-1:0] out_lpid,
  output logic [PID_W-1:0]  out_pid,
  output logic [EA_W-1:0]   out_raddr,
  output logic [2:0]        out_perm,
  output logic [PG_W-1:0]   out_pg_shift,
  output logic              out_fault_instr,
  output logic [EA_W-1:0]   out_far,
  output logic [ERR_W-1:0]  out_err
);
  import rmq_pkg::*;

  localparam int Q_LO   = EA_W - 2;
  localparam int RSV_HI = Q_LO - 1;
  localparam int RSV_LO = Q_LO - RSV_BITS;

  // named internal events
  logic              take_in;
  logic              is_realmode;
  logic              resv_hit;
  logic              quad_illegal;
  logic              seg_fault_c;
  logic [LPID_W-1:0] q_lpid;
  logic [PID_W-1:0]  q_pid;
  logic [EA_W-1:0]   rm_addr;
  logic              f_instr;
  logic [EA_W-1:0]   f_far;

  rmq_quadrant #(.LPID_W(LPID_W), .PID_W(PID_W)) u_quad (
    .hv(in_hv), .quad(in_ea[EA_W-1:Q_LO]), .lpid_reg(reg_lpid),
    .pid_reg(reg_pid), .lpid_q(q_lpid), .pid_q(q_pid), .illegal(quad_illegal)
  );

  rmq_realmode #(.EA_W(EA_W), .CLR_BITS(CLR_BITS)) u_real (
    .ea(in_ea), .rmo(reg_rmo), .raddr(rm_addr)
  );

  rmq_fault #(.EA_W(EA_W)) u_fault (
    .acc(in_acc), .ea(in_ea), .instr(f_instr), .far(f_far)
  );

  assign in_ready    = ~out_valid | out_ready;
  assign take_in     = in_valid & in_ready;
  assign is_realmode = in_hv & ~in_reloc;
  assign resv_hit    = |in_ea[RSV_HI:RSV_LO];
  assign seg_fault_c = ~is_realmode & (resv_hit | quad_illegal);
  assign out_err     = '0;

  // next-result selection
  logic [1:0]        n_kind, n_stages;
  logic [LPID_W-1:0] n_lpid;
  logic [PID_W-1:0]  n_pid;
  logic [EA_W-1:0]   n_raddr, n_far;
  logic [2:0]        n_perm;
  logic [PG_W-1:0]   n_pg;
  logic              n_instr;

  always_comb begin
    n_kind   = RES_QUAL;
    n_stages = '0;
    n_lpid   = '0;
    n_pid    = '0;
    n_raddr  = '0;
    n_far    = '0;
    n_perm   = '0;
    n_pg     = '0;
    n_instr  = 1'b0;
    if (is_realmode) begin
      n_kind  = RES_REAL;
      n_raddr = rm_addr;
      n_perm  = 3'b111;
      n_pg    = PG_W'(MIN_PG_SHIFT);
    end else if (seg_fault_c) begin
      n_kind  = RES_SEGF;
      n_instr = f_instr;
      n_far   = f_far;
    end else begin
      n_lpid   = q_lpid;
      n_pid    = q_pid;
      n_stages = stage_code(in_reloc, in_hv, |q_lpid);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_kind        <= RES_QUAL;
      out_stages      <= '0;
      out_lpid        <= '0;
      out_pid         <= '0;
      out_raddr       <= '0;
      out_perm        <= '0;
      out_pg_shift    <= '0;
      out_fault_instr <= 1'b0;
      out_far         <= '0;
    end else if (take_in) begin
      out_valid       <= 1'b1;
      out_kind        <= n_kind;
      out_stages      <= n_stages;
      out_lpid        <= n_lpid;
      out_pid         <= n_pid;
      out_raddr       <= n_raddr;
      out_perm        <= n_perm;
      out_pg_shift    <= n_pg;
      out_fault_instr <= n_instr;
      out_far         <= n_far;
    end else if (out_ready) begin
      out_valid       <= 1'b0;
    end
  end
endmodule

// File: rtl/rmq_checker.sv
`timescale 1ns/1ps
module rmq_checker #(
  parameter int EA_W   = 64,
  parameter int LPID_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [EA_W-1:0]   in_ea,
  input logic              in_hv,
  input logic              in_reloc,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_kind,
  input logic [1:0]        out_stages,
  input logic [LPID_W-1:0] out_lpid,
  input logic [EA_W-1:0]   out_raddr,
  input logic [2:0]        out_perm,
  input logic              out_fault_instr,
  input logic [EA_W-1:0]   out_far,
  input logic              resv_hit
);
  logic acc_now;
  assign acc_now = in_valid & in_ready;

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_now |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
      $stable(out_raddr) && $stable(out_lpid) && $stable(out_far)));

  assert_real_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_now && in_hv && !in_reloc) |=>
      (out_kind == 2'd1 && out_perm == 3'b111 && out_stages == 2'd0));

  assert_resv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_now && !(in_hv && !in_reloc) && resv_hit) |=> out_kind == 2'd2);

  assert_guest_quad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_now && !in_hv && (in_ea[EA_W-1:EA_W-2] == 2'd1 ||
      in_ea[EA_W-1:EA_W-2] == 2'd2)) |=> out_kind == 2'd2);

  assert_fetch_far_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd2 && out_fault_instr) |->
      (out_far == '0 && out_stages == 2'd0));

  assert_partition_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 2'd0 && out_lpid != '0) |-> out_stages[1]);

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind rmq_top rmq_checker #(.EA_W(EA_W), .LPID_W(LPID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_ea(in_ea), .in_hv(in_hv), .in_reloc(in_reloc),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_stages(out_stages), .out_lpid(out_lpid), .out_raddr(out_raddr),
  .out_perm(out_perm), .out_fault_instr(out_fault_instr), .out_far(out_far),
  .resv_hit(resv_hit)
);

// File: tb/rmq_top_test.sv
`timescale 1ns/1ps
module rmq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_ea = '0;
  logic [1:0]  in_acc = '0;
  logic        in_hv = 1'b0;
  logic        in_reloc = 1'b0;
  logic [11:0] reg_lpid = '0;
  logic [19:0] reg_pid = '0;
  logic [63:0] reg_rmo = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_kind, out_stages;
  logic [11:0] out_lpid;
  logic [19:0] out_pid;
  logic [63:0] out_raddr, out_far;
  logic [2:0]  out_perm;
  logic [6:0]  out_pg_shift;
  logic        out_fault_instr;
  logic [7:0]  out_err;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rmq_top uut (.*);

  // behavioural reference state
  logic        m_valid = 1'b0;
  logic [1:0]  m_kind, m_stages;
  logic [11:0] m_lpid;
  logic [19:0] m_pid;
  logic [63:0] m_raddr, m_far;
  logic [2:0]  m_perm;
  logic [6:0]  m_pg;
  logic        m_instr;

  task automatic predict();
    logic [1:0] q;
    bit bad;
    bit use_lpid, use_pid;
    m_kind = 0; m_stages = 0; m_lpid = 0; m_pid = 0; m_raddr = 0;
    m_far = 0; m_perm = 0; m_pg = 0; m_instr = 0;
    q = in_ea[63:62];
    if (in_hv && !in_reloc) begin
      m_kind  = 2'd1;
      m_raddr = in_ea & 64'h0FFF_FFFF_FFFF_FFFF;
      if (in_ea[63] == 1'b0) m_raddr = m_raddr | reg_rmo;
      m_perm  = 3'b111;
      m_pg    = 7'd12;
    end else begin
      bad = (in_ea[61:52] != 10'd0);
      if (!in_hv && (q == 2'd1 || q == 2'd2)) bad = 1;
      if (bad) begin
        m_kind  = 2'd2;
        m_instr = (in_acc == 2'd0);
        m_far   = m_instr ? 64'd0 : in_ea;
      end else begin
        use_lpid = in_hv ? (q == 2'd1 || q == 2'd2) : 1'b1;
        use_pid  = (q == 2'd0 || q == 2'd1);
        m_lpid   = use_lpid ? reg_lpid : 12'd0;
        m_pid    = use_pid ? reg_pid : 20'd0;
        m_stages = {(m_lpid != 0) || !in_hv, in_reloc};
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_valid = 1'b0;
    else if (in_valid && (!m_valid || out_ready)) begin
      predict();
      m_valid = 1'b1;
    end else if (out_ready) m_valid = 1'b0;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 out_valid", 64'(out_valid), 64'(m_valid));
      chk("R1 in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      if (m_valid) begin
        chk("R3 R6 out_kind", 64'(out_kind), 64'(m_kind));
        chk("R4 R5 out_lpid", 64'(out_lpid), 64'(m_lpid));
        chk("R4 R5 out_pid", 64'(out_pid), 64'(m_pid));
        chk("R8 out_stages", 64'(out_stages), 64'(m_stages));
        chk("R2 out_raddr", out_raddr, m_raddr);
        chk("R2 out_perm", 64'(out_perm), 64'(m_perm));
        chk("R2 out_pg_shift", 64'(out_pg_shift), 64'(m_pg));
        chk("R7 out_fault_instr", 64'(out_fault_instr), 64'(m_instr));
        chk("R7 out_far", out_far, m_far);
        chk("R7 out_err", 64'(out_err), 64'd0);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (ready_mode == 0) out_ready = 1'b1;
    else if (ready_mode == 1) out_ready = ($urandom_range(0, 2) != 0);
    else out_ready = 1'b0;
  end

  task automatic send(input logic [63:0] ea, input logic [1:0] acc,
                      input logic hv, input logic reloc);
    bit got;
    @(negedge clk); #1;
    in_valid = 1'b1; in_ea = ea; in_acc = acc; in_hv = hv; in_reloc = reloc;
    got = 0;
    while (!got) begin
      #3 got = in_ready;
      @(negedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic set_regs(input logic [11:0] l, input logic [19:0] p,
                          input logic [63:0] r);
    @(negedge clk); #1;
    reg_lpid = l; reg_pid = p; reg_rmo = r;
  endtask

  function automatic logic [63:0] mk_ea(input logic [1:0] q, input logic [9:0] rsv,
                                        input logic [51:0] low);
    return {q, rsv, low};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R9 out_valid in reset", 64'(out_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    set_regs(12'h05A, 20'hABCDE, 64'h0000_0040_0000_0000);
    // R2 real mode: bit 63 clear merges the offset, set does not
    send(mk_ea(2'd0, 10'd0, 52'h1234_5678), 2'd1, 1, 0);
    send(64'hF000_0000_0000_1000, 2'd0, 1, 0);
    send(64'h7FF0_0000_0000_2000, 2'd2, 1, 0);
    // R4 hypervisor quadrants with relocation on
    for (int q = 0; q < 4; q++) send(mk_ea(q[1:0], 10'd0, 52'h0ABC), 2'd1, 1, 1);
    // R5 R6 guest quadrants, relocation on and off
    for (int q = 0; q < 4; q++) send(mk_ea(q[1:0], 10'd0, 52'h777), 2'd2, 0, 1);
    for (int q = 0; q < 4; q++) send(mk_ea(q[1:0], 10'd0, 52'h777), 2'd0, 0, 0);
    // R3 R7 reserved bits with each access code
    for (int a = 0; a < 4; a++) send(mk_ea(2'd0, 10'h200 >> a, 52'h55), a[1:0], 1, 1);
    send(mk_ea(2'd3, 10'd1, 52'h9), 2'd2, 0, 1);
    // R8 hypervisor quadrant 1 with zero LPID register: process stage only
    set_regs(12'h000, 20'h00011, 64'd0);
    send(mk_ea(2'd1, 10'd0, 52'h1), 2'd1, 1, 1);
    send(mk_ea(2'd0, 10'd0, 52'h1), 2'd1, 0, 0);
    // R1 stall: result must hold while out_ready is low
    ready_mode = 2;
    send(mk_ea(2'd2, 10'd0, 52'h3), 2'd1, 1, 1);
    repeat (4) @(negedge clk);
    ready_mode = 0;
    repeat (2) @(negedge clk);
    // random traffic with back-pressure
    ready_mode = 1;
    for (int i = 0; i < 300; i++) begin
      logic [9:0] rsv;
      rsv = ($urandom_range(0, 4) == 0) ? 10'($urandom) : 10'd0;
      if (i % 40 == 0) set_regs(12'($urandom), 20'($urandom), {$urandom, $urandom});
      send(mk_ea(2'($urandom), rsv, {20'($urandom), $urandom}),
           2'($urandom), 1'($urandom), 1'($urandom));
    end
    ready_mode = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule